// File: doc/BRIEF.md
# Register Busy-Bit Scoreboard

This block tracks which architectural registers are the destinations of instructions still in the pipeline. It keeps one busy flag per register. The issue stage sets a flag when it sends an instruction with a destination to execute, and the commit stage clears that flag when the instruction retires. Three combinational search ports check a candidate instruction before issue: its two source operands, which catch read-after-write hazards, and its destination. Because there is only one flag per register, the destination search blocks a write-after-write hazard rather than queueing a second owner.

The stall output is the OR of the three search hits. The issue stage holds the instruction while stall is high. A commit in the current cycle is already visible to the searches in that same cycle, so an instruction that depends on the one retiring can issue without an extra bubble. Register 0 is hard-wired and is never tracked. The register count is a parameter with a default of 32.

Top module: `regscore`

## Requirements
- R1: While reset is active and after it is released, every flag is clear, so no search port reports a hit until an insert happens.
- R2: An insert with a valid, nonzero index sets that register's flag at the next clock edge. Searches see the flag from the following cycle on, not in the cycle of the insert.
- R3: A remove with a valid index clears that register's flag. The clear is visible to all three searches in the same cycle as the remove.
- R4: A search port reports a hit only when its valid bit is 1, its index is nonzero, and the flag of that index is set. A port whose valid bit is 0 never hits.
- R5: The three search ports work independently in the same cycle. `stall` is 1 exactly when at least one of `hit_src1`, `hit_src2` or `hit_dst` is 1.
- R6: Register 0 is never marked busy. An insert of index 0 has no effect, and a search of index 0 never hits.
- R7: An insert whose valid bit is 0, or a remove whose valid bit is 0, leaves every flag unchanged.
- R8: When an insert and a remove name the same register in the same cycle, the insert wins and the flag is set after the edge.
- R9: When an insert and a remove name different registers in the same cycle, both take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ins_vld | input | 1 | Insert request: an issued instruction has a destination |
| ins_idx | input | IDX_W | Destination index to mark busy |
| rem_vld | input | 1 | Remove request: a committing instruction has a destination |
| rem_idx | input | IDX_W | Destination index to clear |
| src1_vld | input | 1 | First source field is valid |
| src1_idx | input | IDX_W | First source index |
| src2_vld | input | 1 | Second source field is valid |
| src2_idx | input | IDX_W | Second source index |
| dst_vld | input | 1 | Candidate destination field is valid |
| dst_idx | input | IDX_W | Candidate destination index |
| hit_src1 | output | 1 | First source index is busy |
| hit_src2 | output | 1 | Second source index is busy |
| hit_dst | output | 1 | Candidate destination is busy (write-after-write) |
| stall | output | 1 | Hold issue: any search port hit |

## Verification
Two things can happen in the same cycle: a commit and a search of the register being committed, and a commit and an insert. The bench provokes the first by removing a busy register while all three ports search for it, and expects no hit in that cycle. It provokes the second by inserting and removing the same index, and then two different indices, in one cycle, and reads the resulting flags back through the search ports in the next cycle. A behavioural model of the flag set predicts every output in every cycle, including during a long pseudo-random sequence where these cases occur without being set up.

// File: rtl/regscore_pkg.sv
`timescale 1ns/1ps
package regscore_pkg;
  // Search port ordering inside the hit vector.
  typedef enum logic [1:0] {
    PORT_SRC1 = 2'd0,
    PORT_SRC2 = 2'd1,
    PORT_DST  = 2'd2
  } port_e;

  localparam int NUM_PORTS = 3;
endpackage

// File: rtl/rsb_reset_sync.sv
`timescale 1ns/1ps
module rsb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rsb_busy_bits.sv
`timescale 1ns/1ps
module rsb_busy_bits #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_vld,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_vld,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NREG-1:0]  busy_q,
  output logic [NREG-1:0]  busy_view
);
  logic [NREG-1:0] set_mask;
  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] busy_d;
  logic            busy_en;

  // Decode one-hot set and clear masks; slot 0 is never tracked.
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    if (g == 0) begin : g_zero
      assign set_mask[g] = 1'b0;
      assign clr_mask[g] = 1'b0;
    end else begin : g_reg
      assign set_mask[g] = set_vld && (set_idx == IDX_W'(g));
      assign clr_mask[g] = clr_vld && (clr_idx == IDX_W'(g));
    end
  end

  // The clear of the current cycle is visible to searches at once.
  assign busy_view = busy_q & ~clr_mask;

  // Clear first, then set: a same-index insert wins.
  always_comb begin
    busy_en = set_vld || clr_vld;
    busy_d  = busy_view | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  // R2: a valid nonzero insert leaves the flag set after the edge
  a_r2_insert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_idx != '0) |=> busy_q[$past(set_idx)]);

  // R3: a remove not overridden by an insert clears the flag
  a_r3_remove_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(set_vld && set_idx == clr_idx)) |=> !busy_q[$past(clr_idx)]);

  // R6: slot 0 is never busy
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q[0]);

  // R7: no valid request, no change
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_vld && !clr_vld) |=> $stable(busy_q));

  // R8: same-index insert and remove leave the flag set
  a_r8_insert_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && clr_vld && set_idx == clr_idx && set_idx != '0)
      |=> busy_q[$past(set_idx)]);
endmodule

// File: rtl/rsb_match.sv
`timescale 1ns/1ps
module rsb_match #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  busy_view,
  input  logic             fld_vld,
  input  logic [IDX_W-1:0] fld_idx,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    if (fld_vld && fld_idx != '0) hit = busy_view[fld_idx];
  end
endmodule

// File: rtl/regscore.sv
`timescale 1ns/1ps
module regscore
  import regscore_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             rem_vld,
  input  logic [IDX_W-1:0] rem_idx,
  input  logic             src1_vld,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic             src2_vld,
  input  logic [IDX_W-1:0] src2_idx,
  input  logic             dst_vld,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             hit_src1,
  output logic             hit_src2,
  output logic             hit_dst,
  output logic             stall
);
  logic                 rst_n_int;
  logic [NREG-1:0]      busy_q;
  logic [NREG-1:0]      busy_view;
  logic [NUM_PORTS-1:0] port_vld;
  logic [IDX_W-1:0]     port_idx [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_hit;

  rsb_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  rsb_busy_bits #(.NREG(NREG), .IDX_W(IDX_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .set_vld   (ins_vld),
    .set_idx   (ins_idx),
    .clr_vld   (rem_vld),
    .clr_idx   (rem_idx),
    .busy_q    (busy_q),
    .busy_view (busy_view)
  );

  always_comb begin
    port_vld[PORT_SRC1] = src1_vld;
    port_vld[PORT_SRC2] = src2_vld;
    port_vld[PORT_DST]  = dst_vld;
    port_idx[PORT_SRC1] = src1_idx;
    port_idx[PORT_SRC2] = src2_idx;
    port_idx[PORT_DST]  = dst_idx;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rsb_match #(.NREG(NREG), .IDX_W(IDX_W)) u_match (
      .busy_view (busy_view),
      .fld_vld   (port_vld[p]),
      .fld_idx   (port_idx[p]),
      .hit       (port_hit[p])
    );
  end

  assign hit_src1 = port_hit[PORT_SRC1];
  assign hit_src2 = port_hit[PORT_SRC2];
  assign hit_dst  = port_hit[PORT_DST];
  assign stall    = |port_hit;

  // R1: nothing is busy in the cycle after reset is released
  a_r1_clear_after_reset: assert property (@(posedge clk)
    $rose(rst_n_int) |-> (busy_q == '0));

  // R4: an invalid field never hits
  a_r4_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!src1_vld |-> !hit_src1) and (!src2_vld |-> !hit_src2) and (!dst_vld |-> !hit_dst));

  // R3: a search of the register being removed sees it free
  a_r3_remove_bypass: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rem_vld && src1_vld && src1_idx == rem_idx) |-> !hit_src1);

  // R6: a search of index 0 never hits
  a_r6_zero_no_hit: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dst_idx == '0) |-> !hit_dst);

  // R2: a flag set at an edge is seen by a search of that index next cycle
  a_r2_search_sees_insert: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ins_vld && ins_idx != '0) |=>
      ((src2_vld && src2_idx == $past(ins_idx) && !(rem_vld && rem_idx == src2_idx))
        |-> hit_src2));
endmodule

// File: tb/regscore_test.sv
`timescale 1ns/1ps
module regscore_test;
  localparam int NREG = 32;
  localparam int IW   = $clog2(NREG);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic ins_vld, rem_vld, src1_vld, src2_vld, dst_vld;
  logic [IW-1:0] ins_idx, rem_idx, src1_idx, src2_idx, dst_idx;
  logic hit_src1, hit_src2, hit_dst, stall;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  mdl [NREG];

  regscore #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n),
    .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rem_vld(rem_vld), .rem_idx(rem_idx),
    .src1_vld(src1_vld), .src1_idx(src1_idx),
    .src2_vld(src2_vld), .src2_idx(src2_idx),
    .dst_vld(dst_vld), .dst_idx(dst_idx),
    .hit_src1(hit_src1), .hit_src2(hit_src2),
    .hit_dst(hit_dst), .stall(stall)
  );

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  function automatic bit exp_hit(input bit v, input int idx);
    bit freed;
    freed = rem_vld && (int'(rem_idx) == idx);
    return v && (idx != 0) && mdl[idx] && !freed;
  endfunction

  // Called at a falling edge: drive, check before the rising edge, update model.
  task automatic step(input bit iv, input int ii, input bit rv, input int ri,
                      input bit s1v, input int s1i, input bit s2v, input int s2i,
                      input bit dv, input int di, input string tag);
    bit e1, e2, ed;
    ins_vld = iv;  ins_idx = IW'(ii);
    rem_vld = rv;  rem_idx = IW'(ri);
    src1_vld = s1v; src1_idx = IW'(s1i);
    src2_vld = s2v; src2_idx = IW'(s2i);
    dst_vld = dv;  dst_idx = IW'(di);
    #5;
    e1 = exp_hit(s1v, s1i);
    e2 = exp_hit(s2v, s2i);
    ed = exp_hit(dv, di);
    chk(tag, "hit_src1", hit_src1, e1);
    chk(tag, "hit_src2", hit_src2, e2);
    chk(tag, "hit_dst",  hit_dst,  ed);
    chk({tag, "/R5"}, "stall", stall, e1 | e2 | ed);
    @(posedge clk);
    if (rv) mdl[ri] = 1'b0;
    if (iv && ii != 0) mdl[ii] = 1'b1;
    @(negedge clk);
  endtask

  // Probe three registers without changing anything.
  task automatic look(input int a, input int b, input int c, input string tag);
    step(0, 0, 0, 0, 1, a, 1, b, 1, c, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < NREG; i++) mdl[i] = 1'b0;
    rst_n = 1'b0;
    ins_vld = 0; rem_vld = 0; src1_vld = 0; src2_vld = 0; dst_vld = 0;
    ins_idx = '0; rem_idx = '0; src1_idx = '0; src2_idx = '0; dst_idx = '0;
    repeat (3) @(negedge clk);
    // R1: in reset, even an insert must not make anything busy
    ins_vld = 1; ins_idx = IW'(4); src1_vld = 1; src1_idx = IW'(4);
    #5;
    chk("R1", "hit_src1", hit_src1, 1'b0);
    chk("R1", "stall", stall, 1'b0);
    @(negedge clk);
    ins_vld = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(4, 1, 31, "R1");

    // R2: insert 5, seen next cycle, not same cycle
    step(1, 5, 0, 0, 1, 5, 0, 0, 0, 0, "R2");
    look(5, 5, 5, "R2");
    // R4: invalid fields on a busy index never hit
    step(0, 0, 0, 0, 0, 5, 0, 5, 0, 5, "R4");
    look(6, 4, 5, "R4");
    // R7: invalid remove and invalid insert leave flags as they are
    step(0, 9, 0, 5, 1, 5, 0, 0, 0, 0, "R7");
    look(5, 9, 0, "R7");
    // R3: remove of 5 visible in same cycle on all ports
    step(0, 0, 1, 5, 1, 5, 1, 5, 1, 5, "R3");
    look(5, 5, 5, "R3");
    // R6: register 0 ignored
    step(1, 0, 0, 0, 1, 0, 0, 0, 1, 0, "R6");
    look(0, 0, 0, "R6");
    // R5: independent ports, each one alone causes stall
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 12, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 31, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    look(7, 3, 3, "R5");
    look(3, 12, 3, "R5");
    look(3, 3, 31, "R5");
    look(7, 12, 31, "R5");
    // R8: insert and remove of 12 together leave 12 busy
    step(1, 12, 1, 12, 1, 12, 0, 0, 0, 0, "R8");
    look(12, 12, 12, "R8");
    // R9: insert 20 while removing 7
    step(1, 20, 1, 7, 1, 7, 1, 20, 0, 0, "R9");
    look(7, 20, 7, "R9");

    // Pseudo-random mix (R2 R3 R4 R8 R9 under load)
    seed = 32'h1ace;
    for (int k = 0; k < 400; k++) begin
      int r [10];
      for (int j = 0; j < 10; j++) begin
        seed = seed * 1103515245 + 12345;
        r[j] = (seed >>> 16) & 32'h7fff;
      end
      step(r[0][0], r[1] % NREG, r[0][1], r[2] % NREG,
           r[0][2], r[3] % NREG, r[0][3], r[4] % NREG,
           r[0][4], r[5] % NREG, "R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule